// File: doc/BRIEF.md
# Quadrature Position Counter with Frozen Two-Byte Readout

This block turns a pair of already-filtered quadrature channels into a signed-agnostic 16-bit position count. Every legal Gray-code step of the two channels moves the count by one, up or down, giving four counts per channel period. Alongside the count it emits a one-cycle count pulse, a direction flag and a wrap pulse whenever the counter rolls over in either direction, so that a wider external counter can be chained on.

The host reads the position over an 8-bit bus through a holding register that normally follows the counter. Requesting the upper byte freezes this register on the falling clock edge, and it stays frozen until the lower byte has been read and the output enable released. Both bytes therefore come from one snapshot, even when the counter keeps moving or wraps in the very cycle the read begins.

Top module: `quad_pos_counter`

## Requirements
- R1: With the channel pair written as {chanA,chanB}, the steps 00->10->11->01->00 each count up by one and the reverse steps each count down by one; the counter, cntPulse (high for one cycle) and upDown (1 = up, 0 = down) all update on the first rising edge after the channels change.
- R2: A sample where neither channel changed, or where both changed together, leaves the count unchanged, produces no cntPulse and leaves upDown at its previous value.
- R3: When a count carries the counter from FFFFh to 0000h (up) or from 0000h to FFFFh (down), wrapPulse is high for that same one cycle as cntPulse, and upDown tells the two directions apart.
- R4: With outEnN low and byteSelN high dataOut shows the low byte of the holding register, with outEnN low and byteSelN low it shows the high byte, and with outEnN high it is 00h; while no read is in progress the holding register takes the counter value one rising edge after the counter changes.
- R5: byteSelN and outEnN both low at a falling clock edge freeze the holding register; while frozen, further counts do not alter either byte seen on dataOut.
- R6: The freeze is released only at a falling edge where outEnN is high after a low-byte read (byteSelN high, outEnN low) was seen at an earlier falling edge while frozen; a high-byte read followed by outEnN high without a low-byte read keeps the snapshot.
- R7: A high-byte read requested in the cycle in which wrapPulse is high for an up-count from FFFFh returns FFh on both bytes, the value held before the wrap.
- R8: Synchronous active-low reset clears the counter and holding register to 0000h, ends any freeze, sets upDown to 1 and clears both pulses; the channel levels present during reset cause no count when reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; counting on rising edge, read sequencing on falling edge |
| rstN | input | 1 | Synchronous active-low reset |
| chanA | input | 1 | Filtered quadrature channel A |
| chanB | input | 1 | Filtered quadrature channel B |
| byteSelN | input | 1 | Byte select, low selects the high byte |
| outEnN | input | 1 | Active-low output enable |
| dataOut | output | 8 | Selected byte of the holding register, 00h when disabled |
| cntPulse | output | 1 | One-cycle pulse per decoded count |
| upDown | output | 1 | Direction of the most recent count, 1 = up |
| wrapPulse | output | 1 | One-cycle pulse when the counter rolls over |

## Verification
The count pulse, direction and wrap pulse are due one rising edge after the channel change, while the byte seen on dataOut reflects a new count only after a second rising edge because the holding register lags the counter by one cycle. The freeze takes effect at the falling edge inside the cycle the request is driven, so read requests are driven 5 ns after a rising edge, before that falling edge. Each stimulus vector is therefore held for two edges, with the pulse outputs checked 12 ns after the first edge and the data byte 12 ns after the second, and the directed read sequences count edges the same way.

// File: rtl/qpc_pkg.sv
`timescale 1ns/1ps
package qpc_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic countEn;   // a legal single-channel step was seen
    logic countUp;   // direction of that step
    logic freeze;    // holding register must not follow the counter
  } qpcStrobe_t;

  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_HOLD  = 2'd1,
    RD_LOWRD = 2'd2
  } rdState_e;

  // Next state of {A,B} for one up step: 00 -> 10 -> 11 -> 01 -> 00
  function automatic logic [1:0] upNext(input logic [1:0] ab);
    case (ab)
      2'b00:   upNext = 2'b10;
      2'b10:   upNext = 2'b11;
      2'b11:   upNext = 2'b01;
      default: upNext = 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/qpc_ctrl.sv
`timescale 1ns/1ps
module qpc_ctrl
  import qpc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       chanA,
  input  logic       chanB,
  input  logic       byteSelN,
  input  logic       outEnN,
  output qpcStrobe_t strobe
);

  logic [1:0] curAB;
  logic [1:0] prevAB;
  rdState_e   rdState;
  rdState_e   rdNext;
  logic       stepUp;
  logic       stepDown;

  assign curAB = {chanA, chanB};

  // Previous channel sample; reset loads the live levels so release causes no count
  always_ff @(posedge clk) begin
    prevAB <= curAB;
  end

  always_comb begin
    stepUp   = (curAB == upNext(prevAB));
    stepDown = (prevAB == upNext(curAB));
  end

  // Read sequencing runs on the falling edge
  always_comb begin
    rdNext = rdState;
    case (rdState)
      RD_IDLE: begin
        if (!byteSelN && !outEnN) rdNext = RD_HOLD;
      end
      RD_HOLD: begin
        if (byteSelN && !outEnN) rdNext = RD_LOWRD;
      end
      RD_LOWRD: begin
        if (outEnN) rdNext = RD_IDLE;
      end
      default: rdNext = RD_IDLE;
    endcase
  end

  always_ff @(negedge clk) begin
    if (!rstN) rdState <= RD_IDLE;
    else       rdState <= rdNext;
  end

  always_comb begin
    strobe.countEn = stepUp || stepDown;
    strobe.countUp = stepUp;
    strobe.freeze  = (rdState != RD_IDLE);
  end

  // The snapshot can only start from a high-byte request
  assert_freeze_on_high_read_R5: assert property (
    @(negedge clk) disable iff (!rstN)
      $rose(strobe.freeze) |-> ($past(!byteSelN) && $past(!outEnN))
  );

  // The snapshot can only end with output enable released
  assert_release_on_disable_R6: assert property (
    @(negedge clk) disable iff (!rstN)
      ($fell(strobe.freeze) && $past(rstN)) |-> $past(outEnN)
  );

endmodule

// File: rtl/qpc_datapath.sv
`timescale 1ns/1ps
module qpc_datapath
  import qpc_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  qpcStrobe_t       strobe,
  input  logic             byteSelN,
  input  logic             outEnN,
  output logic [BUS_W-1:0] dataOut,
  output logic             cntPulse,
  output logic             upDown,
  output logic             wrapPulse
);

  localparam int NUM_BYTES = 2;
  localparam int COUNT_W   = NUM_BYTES * BUS_W;
  localparam logic [COUNT_W-1:0] CNT_MAX = {COUNT_W{1'b1}};

  logic [COUNT_W-1:0] count;
  logic [COUNT_W-1:0] holdReg;
  logic               wrapNow;
  logic               byteIdx;

  always_comb begin
    wrapNow = strobe.countEn &&
              ((strobe.countUp && count == CNT_MAX) ||
               (!strobe.countUp && count == '0));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count     <= '0;
      cntPulse  <= 1'b0;
      upDown    <= 1'b1;
      wrapPulse <= 1'b0;
    end else begin
      cntPulse  <= strobe.countEn;
      wrapPulse <= wrapNow;
      if (strobe.countEn) begin
        upDown <= strobe.countUp;
        count  <= strobe.countUp ? count + 1'b1 : count - 1'b1;
      end
    end
  end

  // Holding register follows the counter one edge late unless frozen
  always_ff @(posedge clk) begin
    if (!rstN)               holdReg <= '0;
    else if (!strobe.freeze) holdReg <= count;
  end

  assign byteIdx = !byteSelN;

  always_comb begin
    if (outEnN) dataOut = '0;
    else        dataOut = holdReg[byteIdx*BUS_W +: BUS_W];
  end

  // Each pulse moves the counter by exactly one in the flagged direction
  assert_step_size_R1: assert property (
    @(posedge clk) disable iff (!rstN)
      cntPulse |-> (count == (upDown ? $past(count) + 1'b1 : $past(count) - 1'b1))
  );

  // No pulse means the counter did not move
  assert_no_pulse_no_move_R2: assert property (
    @(posedge clk) disable iff (!rstN)
      (!cntPulse && $past(rstN)) |-> $stable(count)
  );

  // A wrap lands on the far end of the range and comes with a count
  assert_wrap_value_R3: assert property (
    @(posedge clk) disable iff (!rstN)
      wrapPulse |-> (cntPulse && (count == (upDown ? '0 : CNT_MAX)))
  );

  // While frozen across a rising edge the snapshot stays put
  assert_frozen_snapshot_R5: assert property (
    @(negedge clk) disable iff (!rstN)
      (strobe.freeze && $past(rstN)) |-> $stable(holdReg)
  );

endmodule

// File: rtl/quad_pos_counter.sv
`timescale 1ns/1ps
module quad_pos_counter
  import qpc_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chanA,
  input  logic             chanB,
  input  logic             byteSelN,
  input  logic             outEnN,
  output logic [BUS_W-1:0] dataOut,
  output logic             cntPulse,
  output logic             upDown,
  output logic             wrapPulse
);

  qpcStrobe_t strobe;

  qpc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .chanA    (chanA),
    .chanB    (chanB),
    .byteSelN (byteSelN),
    .outEnN   (outEnN),
    .strobe   (strobe)
  );

  qpc_datapath #(
    .BUS_W (BUS_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .byteSelN  (byteSelN),
    .outEnN    (outEnN),
    .dataOut   (dataOut),
    .cntPulse  (cntPulse),
    .upDown    (upDown),
    .wrapPulse (wrapPulse)
  );

endmodule

// File: tb/quad_pos_counter_bench.sv
`timescale 1ns/1ps
module quad_pos_counter_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       chanA = 1'b0;
  logic       chanB = 1'b0;
  logic       byteSelN = 1'b1;
  logic       outEnN = 1'b1;
  logic [7:0] dataOut;
  logic       cntPulse;
  logic       upDown;
  logic       wrapPulse;

  int nChecks = 0;
  int nBad = 0;

  always #10 clk = ~clk;   // 50 MHz

  quad_pos_counter u_quad_pos_counter (
    .clk       (clk),
    .rstN      (rstN),
    .chanA     (chanA),
    .chanB     (chanB),
    .byteSelN  (byteSelN),
    .outEnN    (outEnN),
    .dataOut   (dataOut),
    .cntPulse  (cntPulse),
    .upDown    (upDown),
    .wrapPulse (wrapPulse)
  );

  // {ab[1:0], pulse, up, wrap, lowByte[7:0]}, starting from count 0 with ab = 00
  localparam int NVEC = 13;
  localparam logic [12:0] VEC [NVEC] = '{
    {2'b10, 1'b1, 1'b1, 1'b0, 8'h01},
    {2'b11, 1'b1, 1'b1, 1'b0, 8'h02},
    {2'b01, 1'b1, 1'b1, 1'b0, 8'h03},
    {2'b00, 1'b1, 1'b1, 1'b0, 8'h04},
    {2'b01, 1'b1, 1'b0, 1'b0, 8'h03},
    {2'b01, 1'b0, 1'b0, 1'b0, 8'h03},
    {2'b10, 1'b0, 1'b0, 1'b0, 8'h03},
    {2'b00, 1'b1, 1'b0, 1'b0, 8'h02},
    {2'b11, 1'b0, 1'b0, 1'b0, 8'h02},
    {2'b10, 1'b1, 1'b0, 1'b0, 8'h01},
    {2'b00, 1'b1, 1'b0, 1'b0, 8'h00},
    {2'b01, 1'b1, 1'b0, 1'b1, 8'hFF},
    {2'b00, 1'b1, 1'b1, 1'b1, 8'h00}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Land 5 ns after the next rising edge (drive point)
  task automatic nextSlot();
    @(posedge clk);
    #5;
  endtask

  task automatic setAB(input logic [1:0] ab);
    chanA = ab[1];
    chanB = ab[0];
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nBad);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    // Reset
    repeat (3) nextSlot();
    rstN = 1'b1;
    outEnN = 1'b0;
    byteSelN = 1'b1;
    #7;
    chk("R8 reset low byte", {8'h0, dataOut}, 16'h0000);
    chk("R8 reset cntPulse", {15'h0, cntPulse}, 16'h0);
    chk("R8 reset wrapPulse", {15'h0, wrapPulse}, 16'h0);
    chk("R8 reset upDown", {15'h0, upDown}, 16'h1);
    nextSlot();

    // Table walk: pulses one edge after the change, byte one edge later
    for (int i = 0; i < NVEC; i++) begin
      setAB(VEC[i][12:11]);
      nextSlot();
      #7;
      chk("R1/R2 cntPulse", {15'h0, cntPulse}, {15'h0, VEC[i][10]});
      chk("R1/R3 upDown", {15'h0, upDown}, {15'h0, VEC[i][9]});
      chk("R3 wrapPulse", {15'h0, wrapPulse}, {15'h0, VEC[i][8]});
      nextSlot();
      #7;
      chk("R4 tracking low byte", {8'h0, dataOut}, {8'h0, VEC[i][7:0]});
      nextSlot();
    end

    // R7: read begun in the cycle of an up wrap from FFFFh
    setAB(2'b01);                 // down to FFFFh
    nextSlot();
    setAB(2'b00);                 // up, wraps to 0000h at next edge
    nextSlot();
    byteSelN = 1'b0;
    outEnN = 1'b0;
    setAB(2'b10);                 // keep counting: 1
    #7;
    chk("R7 wrap pulse in read cycle", {15'h0, wrapPulse}, 16'h1);
    chk("R7 high byte", {8'h0, dataOut}, 16'h00FF);
    nextSlot();
    setAB(2'b11);                 // 2
    nextSlot();
    byteSelN = 1'b1;
    setAB(2'b01);                 // 3
    #7;
    chk("R7 low byte from snapshot", {8'h0, dataOut}, 16'h00FF);
    nextSlot();
    outEnN = 1'b1;
    #7;
    chk("R4 disabled output", {8'h0, dataOut}, 16'h0000);
    nextSlot();
    outEnN = 1'b0;
    #7;
    chk("R6 resumed after release", {8'h0, dataOut}, 16'h0003);

    // R6: high read then disable without a low read keeps the snapshot
    nextSlot();
    byteSelN = 1'b0;
    outEnN = 1'b0;
    setAB(2'b00);                 // 4
    nextSlot();
    setAB(2'b10);                 // 5
    #7;
    chk("R5 high byte frozen", {8'h0, dataOut}, 16'h0000);
    nextSlot();
    byteSelN = 1'b1;
    outEnN = 1'b1;
    nextSlot();
    nextSlot();
    outEnN = 1'b0;
    #7;
    chk("R6 still frozen without low read", {8'h0, dataOut}, 16'h0003);
    nextSlot();
    outEnN = 1'b1;
    nextSlot();
    outEnN = 1'b0;
    #7;
    chk("R6 released after low read", {8'h0, dataOut}, 16'h0005);

    // R8: reset while frozen
    nextSlot();
    byteSelN = 1'b0;
    nextSlot();
    rstN = 1'b0;
    byteSelN = 1'b1;
    outEnN = 1'b1;
    nextSlot();
    nextSlot();
    rstN = 1'b1;
    outEnN = 1'b0;
    #7;
    chk("R8 count cleared", {8'h0, dataOut}, 16'h0000);
    chk("R8 upDown after reset", {15'h0, upDown}, 16'h1);
    nextSlot();
    #7;
    chk("R8 no count on release", {15'h0, cntPulse}, 16'h0);
    nextSlot();
    setAB(2'b11);                 // up to 1
    nextSlot();
    nextSlot();
    #7;
    chk("R8 holding register tracks again", {8'h0, dataOut}, 16'h0001);
    byteSelN = 1'b0;
    #1;
    chk("R4 high byte of 0001h", {8'h0, dataOut}, 16'h0000);
    nextSlot();
    outEnN = 1'b1;
    byteSelN = 1'b1;
    nextSlot();

    report();
  end

endmodule